// File: doc/BRIEF.md
# Cascadable Sequential Configuration Memory Reader

This block is the read side of a small configuration store. It plays a stored bitstream out to a loading device, one byte per clock in parallel mode or one bit per clock in serial mode. Two inputs gate the read side. The first is an active-low chip enable. The second is a combined input that enables the outputs when high and resets the read side when low. While the block is enabled, an internal address walks through the array. The walk stops after the highest address, which is the terminal count. At that point the data lines are released and a cascade enable output goes low, so that the next device in a chain takes over the shared clock and data lines.

A preload port writes bytes into the array and reads them back. A sticky read lock blocks both readback and writes through this port. A full erase sets every byte to 8'hFF and is the only way to clear the lock. The lock has no effect on the streaming output.

Top module: `cfgRomReader`

## Requirements
- R1: The block is enabled when `oeRst`=1 and `ceN`=0. In parallel mode it then drives `dataOe`=8'hFF and `dataOut`=the byte at the current address. The address starts at 0 and advances by one on each rising clock.
- R2: The rising clock taken with the terminal-count address as the current byte (in serial mode, with its last bit) ends the stream. While the block stays enabled after that clock, `dataOe`=0, `dataOut`=0 and `ceoN`=0, and further clocks change nothing.
- R3: `ceoN` is 1 whenever the block is not enabled, and also while the block is enabled but still streaming.
- R4: While `oeRst`=0, `dataOe`=0 regardless of `ceN`. A clock edge taken in this state returns the stream to address 0, bit 0.
- R5: While `ceN`=1 (standby), `dataOe`=0 regardless of `oeRst`. A clock edge taken in this state returns the stream to address 0.
- R6: In serial mode `dataOe`=8'h01. `dataOut[0]` carries the current byte MSB first, one bit per clock, with 8 clocks per byte. `dataOut[7:1]`=0.
- R7: `parMode` (1 = parallel, 0 = serial) is sampled only on clock edges taken while the block is not enabled. Changes to it during a stream are ignored.
- R8: When `wrEn`=1 and the lock is clear, a clock edge stores `wrData` at `wrAddr`. When `rdEn`=1, the clock edge loads `rdData` with the byte at `rdAddr`.
- R9: `lockSet`=1 sets the sticky lock. While the lock is set, reads return 8'h00 and writes are ignored. Streaming still outputs the stored contents.
- R10: `eraseReq`=1 sets every byte to 8'hFF and clears the lock on that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| ceN | input | 1 | Chip enable, active low |
| oeRst | input | 1 | High: output enable; low: read-side reset |
| parMode | input | 1 | 1 parallel, 0 serial; sampled while not enabled |
| dataOut | output | 8 | Stream data (bit 0 only in serial mode) |
| dataOe | output | 8 | Per-bit drive enable for dataOut |
| ceoN | output | 1 | Cascade enable to next device, active low |
| wrEn | input | 1 | Preload write strobe |
| wrAddr | input | AW | Preload write address |
| wrData | input | 8 | Preload write byte |
| rdEn | input | 1 | Preload read strobe |
| rdAddr | input | AW | Preload read address |
| rdData | output | 8 | Preload read byte, registered |
| lockSet | input | 1 | Sets the sticky read lock |
| eraseReq | input | 1 | Full erase: fill 8'hFF, clear lock |

## Verification
A wrong address or bit counter shows up on `dataOut` in the same cycle, as the wrong byte or as the wrong bit of the right byte. A terminal-count error shows up as `dataOe` dropping one clock early or late, or as `ceoN` falling at the wrong edge. A lock or erase fault stays hidden until the next preload read, which shows it one clock after the request. It also appears in the next stream, as a byte that a blocked write should have left alone.

// File: rtl/cfgRomPkg.sv
package cfgRomPkg;
  localparam int BYTE_W = 8;
  localparam int BIT_W  = $clog2(BYTE_W);

  typedef struct packed {
    logic             clrAddr;
    logic             stepAddr;
    logic             driveEn;
    logic             parSel;
    logic [BIT_W-1:0] bitSel;
  } ctlStrb_t;
endpackage

// File: rtl/cfgRomCtl.sv
module cfgRomCtl
  import cfgRomPkg::*;
(
  input  logic     clk,
  input  logic     ceN,
  input  logic     oeRst,
  input  logic     parMode,
  input  logic     atTc,
  output ctlStrb_t strb,
  output logic     ceoN
);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

  logic             enabled;
  logic             pastTc;
  logic             parReg;
  logic [BIT_W-1:0] bitCnt;
  logic             byteDone;

  assign enabled  = oeRst & ~ceN;
  assign byteDone = parReg | (bitCnt == LAST_BIT);

  always_ff @(posedge clk) begin
    if (!enabled) begin
      bitCnt <= '0;
      pastTc <= 1'b0;
      parReg <= parMode;
    end else if (!pastTc) begin
      if (byteDone) begin
        bitCnt <= '0;
        if (atTc) pastTc <= 1'b1;
      end else begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strb.clrAddr  = ~enabled;
    strb.stepAddr = enabled & ~pastTc & byteDone & ~atTc;
    strb.driveEn  = enabled & ~pastTc;
    strb.parSel   = parReg;
    strb.bitSel   = bitCnt;
  end

  assign ceoN = ~(enabled & pastTc);

  // R6
  serial_bit_step_chk: assert property (@(posedge clk) disable iff (!oeRst)
    (enabled && !pastTc && !parReg) |=> (bitCnt == BIT_W'($past(bitCnt) + 1'b1)));

  // R2
  tc_only_end_chk: assert property (@(posedge clk) disable iff (!oeRst)
    $rose(pastTc) |-> $past(atTc));

  // R7
  mode_hold_chk: assert property (@(posedge clk) disable iff (!oeRst)
    ($past(enabled) && enabled) |-> $stable(parReg));
endmodule

// File: rtl/cfgRomDp.sv
module cfgRomDp
  import cfgRomPkg::*;
#(
  parameter int TC = 255,
  parameter int AW = 8
) (
  input  logic              clk,
  input  logic              oeRst,
  input  ctlStrb_t          strb,
  output logic              atTc,
  output logic [BYTE_W-1:0] dataOut,
  output logic [BYTE_W-1:0] dataOe,
  input  logic              wrEn,
  input  logic [AW-1:0]     wrAddr,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              rdEn,
  input  logic [AW-1:0]     rdAddr,
  output logic [BYTE_W-1:0] rdData,
  input  logic              lockSet,
  input  logic              eraseReq
);
  localparam int            DEPTH = TC + 1;
  localparam logic [AW-1:0] TC_A  = AW'(TC);

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [AW-1:0]     addr;
  logic              locked;
  logic [BYTE_W-1:0] curByte;
  logic              serBit;

  assign atTc    = (addr == TC_A);
  assign curByte = mem[addr];
  assign serBit  = curByte[BIT_W'(BYTE_W - 1) - strb.bitSel];

  always_ff @(posedge clk) begin
    if (strb.clrAddr)       addr <= '0;
    else if (strb.stepAddr) addr <= addr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (eraseReq) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
      locked <= 1'b0;
    end else begin
      if (wrEn && !locked) mem[wrAddr] <= wrData;
      if (lockSet) locked <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rdEn) rdData <= locked ? '0 : mem[rdAddr];
  end

  always_comb begin
    dataOut = '0;
    dataOe  = '0;
    if (strb.driveEn) begin
      if (strb.parSel) begin
        dataOut = curByte;
        dataOe  = '1;
      end else begin
        dataOut = {{(BYTE_W-1){1'b0}}, serBit};
        dataOe  = BYTE_W'(1);
      end
    end
  end

  // R4
  addr_clear_chk: assert property (@(posedge clk) disable iff (!oeRst)
    $past(strb.clrAddr) |-> (addr == '0));

  // R9
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!oeRst)
    (locked && !eraseReq) |=> locked);

  // R9
  locked_read_zero_chk: assert property (@(posedge clk) disable iff (!oeRst)
    (rdEn && locked) |=> (rdData == '0));

  // R10
  erase_unlock_chk: assert property (@(posedge clk) disable iff (!oeRst)
    eraseReq |=> !locked);
endmodule

// File: rtl/cfgRomReader.sv
module cfgRomReader
  import cfgRomPkg::*;
#(
  parameter int TC = 255,
  localparam int AW = (TC > 0) ? $clog2(TC + 1) : 1
) (
  input  logic              clk,
  input  logic              ceN,
  input  logic              oeRst,
  input  logic              parMode,
  output logic [BYTE_W-1:0] dataOut,
  output logic [BYTE_W-1:0] dataOe,
  output logic              ceoN,
  input  logic              wrEn,
  input  logic [AW-1:0]     wrAddr,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              rdEn,
  input  logic [AW-1:0]     rdAddr,
  output logic [BYTE_W-1:0] rdData,
  input  logic              lockSet,
  input  logic              eraseReq
);
  ctlStrb_t strb;
  logic     atTc;

  cfgRomCtl i_ctl (
    .clk(clk), .ceN(ceN), .oeRst(oeRst), .parMode(parMode),
    .atTc(atTc), .strb(strb), .ceoN(ceoN)
  );

  cfgRomDp #(.TC(TC), .AW(AW)) i_dp (
    .clk(clk), .oeRst(oeRst), .strb(strb), .atTc(atTc),
    .dataOut(dataOut), .dataOe(dataOe),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData),
    .lockSet(lockSet), .eraseReq(eraseReq)
  );

  // R5
  standby_quiet_chk: assert property (@(posedge clk) disable iff (!oeRst)
    ceN |-> (dataOe == '0 && ceoN));

  // R2
  handoff_quiet_chk: assert property (@(posedge clk) disable iff (!oeRst)
    !ceoN |-> (dataOe == '0));
endmodule

// File: tb/test_cfgRomReader.sv
module test_cfgRomReader;
  localparam int TC = 15;
  localparam int AW = $clog2(TC + 1);

  logic          clk = 1'b0;
  logic          ceN = 1'b0, oeRst = 1'b0, parMode = 1'b1;
  logic [7:0]    dataOut, dataOe, rdData;
  logic          ceoN;
  logic          wrEn = 1'b0, rdEn = 1'b0, lockSet = 1'b0, eraseReq = 1'b0;
  logic [AW-1:0] wrAddr = '0, rdAddr = '0;
  logic [7:0]    wrData = '0;

  int checks = 0;
  int errors = 0;

  logic [16:0] expQ[$];
  string       tagQ[$];

  always #4 clk = ~clk;

  cfgRomReader #(.TC(TC)) i_cfgRomReader (
    .clk(clk), .ceN(ceN), .oeRst(oeRst), .parMode(parMode),
    .dataOut(dataOut), .dataOe(dataOe), .ceoN(ceoN),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData),
    .lockSet(lockSet), .eraseReq(eraseReq)
  );

  function automatic logic [7:0] pat(int i);
    return 8'(i * 37 + 5);
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // push expectation for the current cycle, then advance one clock
  task automatic cyc(logic [7:0] eOe, logic [7:0] eDat, logic eCeo, string tag);
    expQ.push_back({eOe, eDat, eCeo});
    tagQ.push_back(tag);
    step();
  endtask

  task automatic check8(logic [7:0] act, logic [7:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic readByte(logic [AW-1:0] a, logic [7:0] exp, string tag);
    rdAddr = a;
    rdEn = 1'b1;
    step();
    rdEn = 1'b0;
    check8(rdData, exp, tag);
  endtask

  task automatic writeByte(logic [AW-1:0] a, logic [7:0] d);
    wrAddr = a;
    wrData = d;
    wrEn = 1'b1;
    step();
    wrEn = 1'b0;
  endtask

  // monitor: compare outputs mid-cycle against the scoreboard
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      logic [16:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      checks++;
      if ({dataOe, dataOut, ceoN} !== e) begin
        errors++;
        $display("FAIL %s: actual oe=%h d=%h ceo=%b expected oe=%h d=%h ceo=%b",
                 t, dataOe, dataOut, ceoN, e[16:9], e[8:1], e[0]);
      end
    end
  end

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1;
    eraseReq = 1'b1;
    step();
    eraseReq = 1'b0;
    // R4 / R3 reset state
    check8(dataOe, 8'h00, "R4 reset oe");
    check8({7'b0, ceoN}, 8'h01, "R3 reset ceo");

    for (int i = 0; i <= TC; i++) writeByte(AW'(i), pat(i));
    readByte(AW'(5), pat(5), "R8 readback");

    // parallel stream, mode latched during reset
    parMode = 1'b1;
    step();
    oeRst = 1'b1;
    for (int k = 0; k <= TC; k++) begin
      if (k == 5)  parMode = 1'b0;
      if (k == 10) parMode = 1'b1;
      cyc(8'hFF, pat(k), 1'b1, (k > 5 && k < 10) ? "R7 mode ignored" : "R1 parallel");
    end
    cyc(8'h00, 8'h00, 1'b0, "R2 past tc");
    cyc(8'h00, 8'h00, 1'b0, "R2 saturate");
    ceN = 1'b1;
    cyc(8'h00, 8'h00, 1'b1, "R5 standby");
    ceN = 1'b0;
    cyc(8'hFF, pat(0), 1'b1, "R5 restart");
    cyc(8'hFF, pat(1), 1'b1, "R1 second byte");
    parMode = 1'b0;
    oeRst = 1'b0;
    cyc(8'h00, 8'h00, 1'b1, "R4 abort");
    oeRst = 1'b1;
    for (int k = 0; k <= TC; k++)
      for (int b = 7; b >= 0; b--)
        cyc(8'h01, {7'b0, pat(k)[b]}, 1'b1, "R6 serial");
    cyc(8'h00, 8'h00, 1'b0, "R2 serial end");
    cyc(8'h00, 8'h00, 1'b0, "R2 serial hold");

    // lock behaviour
    oeRst = 1'b0;
    parMode = 1'b1;
    lockSet = 1'b1;
    step();
    lockSet = 1'b0;
    readByte(AW'(3), 8'h00, "R9 locked read");
    writeByte(AW'(3), 8'hAA);
    step();
    oeRst = 1'b1;
    for (int k = 0; k <= TC; k++) cyc(8'hFF, pat(k), 1'b1, "R9 stream while locked");
    cyc(8'h00, 8'h00, 1'b0, "R2 locked end");

    // erase
    oeRst = 1'b0;
    eraseReq = 1'b1;
    step();
    eraseReq = 1'b0;
    readByte(AW'(3), 8'hFF, "R10 erased read");
    oeRst = 1'b1;
    for (int k = 0; k <= TC; k++) cyc(8'hFF, 8'hFF, 1'b1, "R10 erased stream");
    oeRst = 1'b0;
    step();
    writeByte(AW'(0), 8'h5A);
    readByte(AW'(0), 8'h5A, "R8 write after erase");

    step();
    step();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule